// File: doc/BRIEF.md
# Strobed Parallel-to-Serial Character Transmitter

This block turns a seven-bit character, presented in parallel together with a one-cycle strobe, into an asynchronous serial frame on a single line. A keyboard or any auxiliary source sets the data lines first and raises the strobe afterwards. The block captures the character on that strobe and shifts it out. The frame is a low start bit, the seven data bits least significant first, an even-parity bit and then one or two high stop bits. Bit timing comes from an enable pulse that runs at eight times the bit rate. The block counts eight of these pulses for each bit.

A rate-code input picks the stop-bit count. The slowest rate uses two stop bits and every other rate uses one. A separate break request pulls the line low for a fixed number of system clock cycles on each rising edge of the request. A break takes precedence over any frame. An echo output carries the same digital stream, so that a local or half-duplex path can merge it into the receive side. Line level conversion and the bit-rate oscillator live outside this block.

Top module: `strobed_char_tx`

## Requirements
- R1: After reset, and whenever no frame and no break is in progress, `ser_out` is high (mark), and `busy` and `brk_active` are low.
- R2: A strobe sampled high while idle, with no break active or starting, captures `char_in`. From the next cycle `busy` is high and `ser_out` is low (start bit). `busy` stays high until the end of the last stop bit.
- R3: After the start bit, the seven data bits go out with bit 0 first, one bit per bit time.
- R4: The bit after bit 6 is the parity bit. It equals the XOR of the seven data bits, so the count of ones in the data and parity bits together is even.
- R5: The stop count follows the rate code captured with the strobe. Code 0 (slowest rate) gives two high stop bits and any other code gives one. `busy` falls right after the last stop bit ends, and changing `rate_sel` during a frame has no effect on that frame.
- R6: A strobe that arrives while a frame is in progress is ignored. The current frame goes on unchanged and no second frame follows it.
- R7: Each rising edge of `brk_req` drives `ser_out` low for exactly BREAK_CYCLES clock cycles, with `brk_active` high over that span. Holding the request high does not lengthen the break, and a held request does not start another one.
- R8: Break takes priority over frames. A strobe in the same cycle as a break start, or during a break, starts no frame. A break that starts during a frame abandons that frame, and `busy` drops at once.
- R9: `echo_out` carries the same value as `ser_out` in every cycle.
- R10: Only cycles with `tick8` high advance the bit timing. Each bit lasts exactly eight `tick8` pulses, however many idle cycles separate the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick8 | input | 1 | One-cycle enable at eight times the bit rate |
| char_in | input | 7 | Parallel character, stable before the strobe |
| char_stb | input | 1 | Strobe that requests transmission of `char_in` |
| rate_sel | input | 4 | Rate code; 0 is the slowest rate and selects two stop bits |
| brk_req | input | 1 | Break request; each rising edge starts one timed break |
| ser_out | output | 1 | Serial line, high when idle |
| echo_out | output | 1 | Copy of the serial stream for local echo |
| busy | output | 1 | High while a frame is being sent |
| brk_active | output | 1 | High while a break holds the line low |

## Verification
The bench sends frames whose data have an even number of ones (0x41, 0x55) and an odd number (0x7F, 0x01), so a wrong or inverted parity bit shows up. The alternating pattern 0x55 exposes a reversed bit order. Frames are sent with rate codes 0, 1 and 3 and with `tick8` gaps of 0, 1 and 3 idle cycles, which separates the one-stop and two-stop lengths and checks that only enable pulses count. Breaks are tried as a short pulse, as a long hold, together with a strobe, with a strobe in the middle, and on top of a frame in flight. These cases tell a timed break apart from a level-following one and show that break wins over every frame.

// File: rtl/tx_pkg.sv
// Shared types for the strobed character transmitter.
// Assumes nothing beyond IEEE 1800-2017 packages.
`timescale 1ns/1ps
package tx_pkg;

    // Phase of the frame currently on the line.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } tx_phase_e;

endpackage

// File: rtl/tx_bit_timer.sv
// Divides the oversampling enable down to one pulse per bit time.
// Assumes: run is low for at least the cycle in which a frame is loaded,
// so every frame starts from a cleared count.
`timescale 1ns/1ps
module tx_bit_timer #(
    parameter int OVERSAMPLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);

    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] sub_q;

    // Count enable pulses inside the current bit; clear while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (!run) begin
            sub_q <= '0;
        end else if (tick) begin
            sub_q <= (sub_q == LAST) ? '0 : sub_q + CW'(1);
        end
    end

    // Last enable pulse of a bit closes that bit.
    assign bit_end = run && tick && (sub_q == LAST);

endmodule

// File: rtl/tx_break_gen.sv
// Produces one timed break per rising edge of the request.
// Assumes: BREAK_CYCLES >= 1; an edge that arrives during a break is dropped.
`timescale 1ns/1ps
module tx_break_gen #(
    parameter int BREAK_CYCLES = 2_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active,
    output logic start
);

    localparam int BW = $clog2(BREAK_CYCLES + 1);
    localparam logic [BW-1:0] LOAD_VAL = BW'(BREAK_CYCLES);

    logic          req_q;
    logic [BW-1:0] left_q;

    // Remember last request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    assign active = (left_q != '0);
    assign start  = req && !req_q && !active;

    // Load the break length on a start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD_VAL;
        end else if (active) begin
            left_q <= left_q - BW'(1);
        end
    end

endmodule

// File: rtl/tx_frame_seq.sv
// Walks one frame through start, data, parity and stop phases.
// Parity is accumulated serially, one data bit per bit time.
// Assumes: load and abort are never high together (the top gives abort
// priority by masking load).
`timescale 1ns/1ps
module tx_frame_seq
    import tx_pkg::*;
#(
    parameter int DATA_W    = 7,
    parameter int RATE_W    = 4,
    parameter int SLOW_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              abort,
    input  logic              bit_end,
    input  logic [DATA_W-1:0] data,
    input  logic [RATE_W-1:0] rate,
    output logic              line,
    output logic              busy
);

    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0]     LAST_IDX = IW'(DATA_W - 1);
    localparam logic [RATE_W-1:0] SLOW     = RATE_W'(SLOW_CODE);

    tx_phase_e         phase_q;
    logic [DATA_W-1:0] shreg_q;
    logic [IW-1:0]     idx_q;
    logic              par_q;
    logic              two_stop_q;
    logic              extra_stop_q;

    // Frame state: load, abandon or advance one bit per bit_end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            shreg_q      <= '0;
            idx_q        <= '0;
            par_q        <= 1'b0;
            two_stop_q   <= 1'b0;
            extra_stop_q <= 1'b0;
        end else if (abort) begin
            phase_q <= PH_IDLE;
        end else if (load) begin
            phase_q      <= PH_START;
            shreg_q      <= data;
            idx_q        <= '0;
            par_q        <= 1'b0;
            two_stop_q   <= (rate == SLOW);
            extra_stop_q <= 1'b0;
        end else if (bit_end) begin
            unique case (phase_q)
                PH_START: phase_q <= PH_DATA;
                PH_DATA: begin
                    par_q   <= par_q ^ shreg_q[0];
                    shreg_q <= shreg_q >> 1;
                    if (idx_q == LAST_IDX) phase_q <= PH_PARITY;
                    else                   idx_q   <= idx_q + IW'(1);
                end
                PH_PARITY: begin
                    phase_q      <= PH_STOP;
                    extra_stop_q <= two_stop_q;
                end
                PH_STOP: begin
                    if (extra_stop_q) extra_stop_q <= 1'b0;
                    else              phase_q      <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Line level for the current phase.
    always_comb begin
        unique case (phase_q)
            PH_START:  line = 1'b0;
            PH_DATA:   line = shreg_q[0];
            PH_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/strobed_char_tx.sv
// Top of the strobed parallel-to-serial character transmitter.
// Joins the bit timer, the frame sequencer and the break generator, and
// decides which of strobe and break reaches the line.
// Assumes: tick8 is a one-cycle enable at eight times the bit rate and
// char_in is stable in the cycle char_stb is high.
`timescale 1ns/1ps
module strobed_char_tx #(
    parameter int DATA_W       = 7,
    parameter int OVERSAMPLE   = 8,
    parameter int RATE_W       = 4,
    parameter int SLOW_CODE    = 0,
    parameter int BREAK_CYCLES = 2_400_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick8,
    input  logic [DATA_W-1:0] char_in,
    input  logic              char_stb,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              brk_req,
    output logic              ser_out,
    output logic              echo_out,
    output logic              busy,
    output logic              brk_active
);

    logic bit_end;
    logic brk_start;
    logic frame_line;
    logic load;

    tx_break_gen #(
        .BREAK_CYCLES (BREAK_CYCLES)
    ) u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (brk_req),
        .active (brk_active),
        .start  (brk_start)
    );

    tx_bit_timer #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .tick    (tick8),
        .bit_end (bit_end)
    );

    // A strobe only starts a frame when nothing else owns the line.
    assign load = char_stb && !busy && !brk_active && !brk_start;

    tx_frame_seq #(
        .DATA_W    (DATA_W),
        .RATE_W    (RATE_W),
        .SLOW_CODE (SLOW_CODE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .abort   (brk_start),
        .bit_end (bit_end),
        .data    (char_in),
        .rate    (rate_sel),
        .line    (frame_line),
        .busy    (busy)
    );

    // Break forces space; otherwise the frame drives the line.
    assign ser_out  = frame_line && !brk_active;
    assign echo_out = ser_out;

endmodule

// File: rtl/strobed_char_tx_chk.sv
// Property checker for strobed_char_tx, attached with bind.
// Assumes the port names of the top module.
`timescale 1ns/1ps
module strobed_char_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick8,
    input logic char_stb,
    input logic brk_req,
    input logic ser_out,
    input logic busy,
    input logic brk_active
);

    logic req_seen_q;

    // Own copy of the previous request level.
    always_ff @(posedge clk) begin
        if (!rst_n) req_seen_q <= 1'b0;
        else        req_seen_q <= brk_req;
    end

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk_active) |-> ser_out); // R1

    AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !busy && !brk_active && !brk_req) |=> (busy && !ser_out)); // R2

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick8 && !brk_req) |=> busy); // R2

    AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && char_stb && !tick8 && !brk_req) |=> $stable(ser_out)); // R6

    AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_active |-> (!ser_out && !busy)); // R7

    AST_BREAK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_active) |-> ser_out); // R7

    AST_BREAK_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && brk_req && !req_seen_q && !brk_active) |=> (brk_active && !busy)); // R8

endmodule

bind strobed_char_tx strobed_char_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick8      (tick8),
    .char_stb   (char_stb),
    .brk_req    (brk_req),
    .ser_out    (ser_out),
    .busy       (busy),
    .brk_active (brk_active)
);

// File: tb/sim_strobed_char_tx.sv
// Directed bench for strobed_char_tx: one task per scenario.
`timescale 1ns/1ps
module sim_strobed_char_tx;

    localparam int BRK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick8 = 1'b0;
    logic [6:0] char_in = '0;
    logic       char_stb = 1'b0;
    logic [3:0] rate_sel = '0;
    logic       brk_req = 1'b0;
    logic       ser_out;
    logic       echo_out;
    logic       busy;
    logic       brk_active;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    strobed_char_tx #(
        .BREAK_CYCLES (BRK)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick8      (tick8),
        .char_in    (char_in),
        .char_stb   (char_stb),
        .rate_sel   (rate_sel),
        .brk_req    (brk_req),
        .ser_out    (ser_out),
        .echo_out   (echo_out),
        .busy       (busy),
        .brk_active (brk_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic tick(input int gap);
        tick8 = 1'b1;
        @(negedge clk);
        tick8 = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_out == 1'b1, "R1 idle line", ser_out, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(brk_active == 1'b0, "R1 brk_active", brk_active, 0);
        chk(echo_out == 1'b1, "R9 echo idle", echo_out, 1);
    endtask

    // R2..R6, R9, R10: one full frame, sampled mid-bit
    task automatic t_frame(input logic [6:0] d, input logic [3:0] rate,
                           input int gap, input bit intrude);
        logic [10:0] expb;
        int nslots;
        string dtag;
        expb   = {1'b1, 1'b1, ^d, d, 1'b0};
        nslots = (rate == 4'd0) ? 11 : 10;
        char_in  = d;
        rate_sel = rate;
        char_stb = 1'b1;
        @(negedge clk);
        char_stb = 1'b0;
        char_in  = ~d;
        for (int s = 0; s < nslots; s++) begin
            repeat (4) tick(gap);
            if (s == 0)      dtag = "R2 start bit";
            else if (s < 8)  dtag = (gap != 0) ? "R3/R10 data bit" : "R3 data bit";
            else if (s == 8) dtag = "R4 parity bit";
            else             dtag = "R5 stop bit";
            chk(ser_out == expb[s], dtag, ser_out, int'(expb[s]));
            chk(echo_out == ser_out, "R9 echo", echo_out, ser_out);
            chk(busy == 1'b1, "R2 busy in frame", busy, 1);
            if (intrude && s == 3) begin
                char_in  = 7'h15;
                char_stb = 1'b1;
                rate_sel = (rate == 4'd0) ? 4'd1 : 4'd0;
                @(negedge clk);
                char_stb = 1'b0;
            end
            repeat (4) tick(gap);
        end
        chk(busy == 1'b0, "R5 busy ends after last stop", busy, 0);
        chk(ser_out == 1'b1, "R1 mark after frame", ser_out, 1);
        repeat (16) tick(gap);
        chk(busy == 1'b0, intrude ? "R6 no second frame" : "R1 stays idle", busy, 0);
        chk(ser_out == 1'b1, intrude ? "R6 line idle" : "R1 line idle", ser_out, 1);
    endtask

    // R7, R8: break pulse, hold, strobe clash
    task automatic t_break(input int hold, input bit with_stb, input bit stb_mid,
                           input string tag);
        int n;
        bit busy_seen;
        n = 0;
        busy_seen = 1'b0;
        brk_req = 1'b1;
        if (with_stb) begin
            char_in  = 7'h33;
            char_stb = 1'b1;
        end
        @(negedge clk);
        char_stb = 1'b0;
        if (hold == 0) brk_req = 1'b0;
        chk(brk_active == 1'b1, {tag, " brk_active"}, brk_active, 1);
        while (ser_out == 1'b0 && n < 2000) begin
            if (busy) busy_seen = 1'b1;
            n++;
            if (stb_mid && n == 5) char_stb = 1'b1;
            if (stb_mid && n == 6) char_stb = 1'b0;
            @(negedge clk);
        end
        char_stb = 1'b0;
        chk(n == BRK, {tag, " break length"}, n, BRK);
        chk(!busy_seen, {tag, " no frame during break"}, busy_seen, 0);
        if (hold > n) begin
            repeat (hold - n) @(negedge clk);
            chk(ser_out == 1'b1, "R7 held request gives no more space", ser_out, 1);
        end
        brk_req = 1'b0;
        repeat (20) tick(0);
        chk(busy == 1'b0, {tag, " idle after break"}, busy, 0);
        chk(ser_out == 1'b1, {tag, " mark after break"}, ser_out, 1);
    endtask

    // R8: break in the middle of a frame abandons it
    task automatic t_abort();
        char_in  = 7'h7F;
        rate_sel = 4'd1;
        char_stb = 1'b1;
        @(negedge clk);
        char_stb = 1'b0;
        repeat (12) tick(0);
        chk(busy == 1'b1, "R8 frame running before break", busy, 1);
        t_break(0, 1'b0, 1'b0, "R8 abort");
    endtask

    initial begin
        t_reset();
        t_frame(7'h41, 4'd0, 1, 1'b0);
        t_frame(7'h55, 4'd3, 0, 1'b0);
        t_frame(7'h7F, 4'd1, 3, 1'b0);
        t_frame(7'h2A, 4'd2, 0, 1'b1);
        t_frame(7'h00, 4'd0, 0, 1'b1);
        t_break(0, 1'b0, 1'b0, "R7 pulse");
        t_break(3 * BRK, 1'b0, 1'b0, "R7 hold");
        t_break(0, 1'b1, 1'b0, "R8 clash");
        t_break(0, 1'b0, 1'b1, "R8 strobe mid");
        t_abort();
        t_frame(7'h01, 4'd5, 2, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule